// File: doc/BRIEF.md
# Per-Bin Averaging Energy Detector

This block sits behind a 64-point transform and decides, bin by bin, whether a frequency channel carries a signal or only noise. It takes one complex bin per clock, together with the bin's index and a marker on the first bin of each frame. For every bin it forms the power as the sum of the squared real and imaginary parts. It then smooths that power over the sixteen most recent frames and compares the smoothed value with a programmable threshold.

Each bin keeps its own sliding window. A per-bin running sum is updated every frame: the newest power is added and the power that entered sixteen frames earlier is subtracted. A shift by four bits turns the sum into the mean. While the window is still filling, the powers not yet received count as zero. A qualifier output stays low until the sixteenth frame has arrived. The block never stalls, and every result leaves three clocks after its bin entered.

Top module: `bin_energy_detector`

## Requirements
- R1: The power of a bin is re*re + im*im, where re and im are 8-bit two's-complement values. In the first frame after reset, out_avg for a bin equals that power shifted right by 4.
- R2: From the sixteenth frame onward, out_avg for bin b equals floor(S/16), where S is the sum of the powers of bin b in the 16 most recent frames. Powers older than that no longer contribute.
- R3: In frame number f, for f below 16, out_avg equals floor(S/16), where S sums the f powers received so far for that bin. During these frames out_primed is 0.
- R4: out_primed is 1 for every valid result from the sixteenth frame after reset onward, and it stays 1 from then on.
- R5: out_busy is 1 when out_avg is strictly greater than threshold, and 0 when out_avg is equal to or below it. It is 0 in every cycle where out_valid is 0.
- R6: A bin presented with in_valid high produces out_valid high exactly 3 clock edges later, and out_bin then carries the same index.
- R7: One bin is accepted every clock with no back-pressure. A cycle with in_valid low produces a cycle with out_valid low three edges later and does not change any bin's history.
- R8: While rst_n is low and directly after its release, out_valid, out_busy and out_primed are 0.
- R9: Full-scale inputs (re = im = -128, power 32768) give an average of exactly 32768, with no wrap in the sum.
- R10: A frame starts only on a cycle where in_sof and in_valid are both 1. An in_sof pulse with in_valid low has no effect on the frame count or on the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bin present this cycle |
| in_sof | input | 1 | Marks the first bin of a frame (only with in_valid) |
| in_bin | input | 6 | Frequency bin index |
| in_re | input | 8 | Real part, signed |
| in_im | input | 8 | Imaginary part, signed |
| threshold | input | 17 | Decision threshold on the averaged power |
| out_valid | output | 1 | Result present this cycle |
| out_bin | output | 6 | Bin index of the result |
| out_avg | output | 17 | Mean power over the window |
| out_busy | output | 1 | 1 when the channel is occupied, 0 when idle |
| out_primed | output | 1 | Window fully filled, decision trustworthy |

## Verification
The assertions assume that a bin index never repeats within three consecutive valid cycles. They also assume that every frame opens with in_sof and delivers each index exactly once, because only then is the stored history read back in the slot where it was written. The stimulus always sends whole frames in ascending bin order and starts each one with in_sof. Idle cycles and stray frame markers are placed only between bins, never in place of one. The threshold is changed only after the pipeline has drained.

// File: rtl/bed_pkg.sv
package bed_pkg;
    // Default geometry of the detector
    localparam int DEF_BINS  = 64;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_IN_W  = 8;

    // Width of a squared-magnitude value for a signed input of width w
    function automatic int pwr_width(input int w);
        return 2 * w + 1;
    endfunction
endpackage

// File: rtl/bed_power_calc.sv
module bed_power_calc #(
    parameter int IN_W  = 8,
    parameter int BIN_W = 6,
    parameter int PTR_W = 4,
    localparam int PWR_W = 2 * IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BIN_W-1:0]        in_bin,
    input  logic signed [IN_W-1:0]  in_re,
    input  logic signed [IN_W-1:0]  in_im,
    input  logic [PTR_W-1:0]        tag_slot,
    input  logic                    tag_first,
    input  logic                    tag_wrap,
    input  logic                    tag_primed,
    output logic                    s1_valid,
    output logic [BIN_W-1:0]        s1_bin,
    output logic [PWR_W-1:0]        s1_pwr,
    output logic [PTR_W-1:0]        s1_slot,
    output logic                    s1_first,
    output logic                    s1_wrap,
    output logic                    s1_primed
);
    typedef struct packed {
        logic             valid;
        logic [BIN_W-1:0] bin;
        logic [PWR_W-1:0] pwr;
        logic [PTR_W-1:0] slot;
        logic             first;
        logic             wrap;
        logic             primed;
    } st_t;

    st_t st_d, st_q;
    logic signed [2*IN_W-1:0] re_sq;
    logic signed [2*IN_W-1:0] im_sq;

    always_comb begin
        re_sq = in_re * in_re;
        im_sq = in_im * in_im;
        st_d = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.bin    = in_bin;
            st_d.pwr    = PWR_W'($unsigned(re_sq)) + PWR_W'($unsigned(im_sq));
            st_d.slot   = tag_slot;
            st_d.first  = tag_first;
            st_d.wrap   = tag_wrap;
            st_d.primed = tag_primed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid  = st_q.valid;
    assign s1_bin    = st_q.bin;
    assign s1_pwr    = st_q.pwr;
    assign s1_slot   = st_q.slot;
    assign s1_first  = st_q.first;
    assign s1_wrap   = st_q.wrap;
    assign s1_primed = st_q.primed;
endmodule

// File: rtl/bed_frame_tracker.sv
module bed_frame_tracker #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [PTR_W-1:0] cur_slot,
    output logic             cur_first,
    output logic             cur_wrap,
    output logic             cur_primed
);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] slot;
        logic [CNT_W-1:0] frames;
    } st_t;

    st_t  st_d, st_q;
    logic advance;

    always_comb begin
        advance = in_valid && in_sof;
        st_d = st_q;
        if (advance) begin
            if (st_q.frames != CNT_SAT)
                st_d.frames = st_q.frames + 1'b1;
            if (st_q.frames != '0)
                st_d.slot = st_q.slot + 1'b1;
        end
        // Tags describe the frame the current input belongs to
        cur_slot   = st_d.slot;
        cur_first  = (st_d.frames <= CNT_W'(1));
        cur_wrap   = (st_d.frames > CNT_FULL);
        cur_primed = (st_d.frames >= CNT_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bed_avg_store.sv
module bed_avg_store #(
    parameter int NUM_BINS = 64,
    parameter int DEPTH    = 16,
    parameter int PWR_W    = 17,
    localparam int BIN_W   = $clog2(NUM_BINS),
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int SUM_W   = PWR_W + PTR_W,
    localparam int HIST_N  = NUM_BINS * DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [BIN_W-1:0] s1_bin,
    input  logic [PWR_W-1:0] s1_pwr,
    input  logic [PTR_W-1:0] s1_slot,
    input  logic             s1_first,
    input  logic             s1_wrap,
    input  logic             s1_primed,
    output logic             s2_valid,
    output logic [BIN_W-1:0] s2_bin,
    output logic [PWR_W-1:0] s2_avg,
    output logic             s2_primed
);
    typedef struct packed {
        logic             valid;
        logic [BIN_W-1:0] bin;
        logic [PWR_W-1:0] avg;
        logic             primed;
    } st_t;

    logic [SUM_W-1:0] sum_mem  [NUM_BINS];
    logic [PWR_W-1:0] hist_mem [HIST_N];

    st_t                    st_d, st_q;
    logic [BIN_W+PTR_W-1:0] hist_addr;
    logic [SUM_W-1:0]       old_sum;
    logic [PWR_W-1:0]       old_pwr;
    logic [SUM_W-1:0]       new_sum;

    always_comb begin
        hist_addr = {s1_bin, s1_slot};
        // Unwritten entries count as zero while the window fills
        old_sum   = s1_first ? '0 : sum_mem[s1_bin];
        old_pwr   = s1_wrap ? hist_mem[hist_addr] : '0;
        new_sum   = old_sum + SUM_W'(s1_pwr) - SUM_W'(old_pwr);
        st_d = st_q;
        st_d.valid = s1_valid;
        if (s1_valid) begin
            st_d.bin    = s1_bin;
            st_d.avg    = new_sum[SUM_W-1:PTR_W];
            st_d.primed = s1_primed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            sum_mem[s1_bin]     <= new_sum;
            hist_mem[hist_addr] <= s1_pwr;
        end
    end

    assign s2_valid  = st_q.valid;
    assign s2_bin    = st_q.bin;
    assign s2_avg    = st_q.avg;
    assign s2_primed = st_q.primed;
endmodule

// File: rtl/bed_threshold_cmp.sv
module bed_threshold_cmp #(
    parameter int BIN_W = 6,
    parameter int PWR_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s2_valid,
    input  logic [BIN_W-1:0] s2_bin,
    input  logic [PWR_W-1:0] s2_avg,
    input  logic             s2_primed,
    input  logic [PWR_W-1:0] threshold,
    output logic             out_valid,
    output logic [BIN_W-1:0] out_bin,
    output logic [PWR_W-1:0] out_avg,
    output logic             out_busy,
    output logic             out_primed
);
    typedef struct packed {
        logic             valid;
        logic [BIN_W-1:0] bin;
        logic [PWR_W-1:0] avg;
        logic             busy;
        logic             primed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.valid = s2_valid;
        st_d.busy  = 1'b0;
        if (s2_valid) begin
            st_d.bin    = s2_bin;
            st_d.avg    = s2_avg;
            st_d.busy   = (s2_avg > threshold);
            st_d.primed = s2_primed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_bin    = st_q.bin;
    assign out_avg    = st_q.avg;
    assign out_busy   = st_q.busy;
    assign out_primed = st_q.primed;
endmodule

// File: rtl/bin_energy_detector.sv
module bin_energy_detector #(
    parameter int NUM_BINS = bed_pkg::DEF_BINS,
    parameter int DEPTH    = bed_pkg::DEF_DEPTH,
    parameter int IN_W     = bed_pkg::DEF_IN_W,
    localparam int BIN_W   = $clog2(NUM_BINS),
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int PWR_W   = bed_pkg::pwr_width(IN_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [BIN_W-1:0]       in_bin,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    input  logic [PWR_W-1:0]       threshold,
    output logic                   out_valid,
    output logic [BIN_W-1:0]       out_bin,
    output logic [PWR_W-1:0]       out_avg,
    output logic                   out_busy,
    output logic                   out_primed
);
    logic [PTR_W-1:0] tag_slot;
    logic             tag_first, tag_wrap, tag_primed;

    logic             s1_valid, s1_first, s1_wrap, s1_primed;
    logic [BIN_W-1:0] s1_bin;
    logic [PWR_W-1:0] s1_pwr;
    logic [PTR_W-1:0] s1_slot;

    logic             s2_valid, s2_primed;
    logic [BIN_W-1:0] s2_bin;
    logic [PWR_W-1:0] s2_avg;

    bed_frame_tracker #(.DEPTH(DEPTH)) u_frames (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .cur_slot(tag_slot), .cur_first(tag_first), .cur_wrap(tag_wrap),
        .cur_primed(tag_primed)
    );

    bed_power_calc #(.IN_W(IN_W), .BIN_W(BIN_W), .PTR_W(PTR_W)) u_power (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bin(in_bin),
        .in_re(in_re), .in_im(in_im), .tag_slot(tag_slot),
        .tag_first(tag_first), .tag_wrap(tag_wrap), .tag_primed(tag_primed),
        .s1_valid(s1_valid), .s1_bin(s1_bin), .s1_pwr(s1_pwr),
        .s1_slot(s1_slot), .s1_first(s1_first), .s1_wrap(s1_wrap),
        .s1_primed(s1_primed)
    );

    bed_avg_store #(.NUM_BINS(NUM_BINS), .DEPTH(DEPTH), .PWR_W(PWR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_bin(s1_bin),
        .s1_pwr(s1_pwr), .s1_slot(s1_slot), .s1_first(s1_first),
        .s1_wrap(s1_wrap), .s1_primed(s1_primed), .s2_valid(s2_valid),
        .s2_bin(s2_bin), .s2_avg(s2_avg), .s2_primed(s2_primed)
    );

    bed_threshold_cmp #(.BIN_W(BIN_W), .PWR_W(PWR_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_bin(s2_bin),
        .s2_avg(s2_avg), .s2_primed(s2_primed), .threshold(threshold),
        .out_valid(out_valid), .out_bin(out_bin), .out_avg(out_avg),
        .out_busy(out_busy), .out_primed(out_primed)
    );
endmodule

// File: rtl/bed_checker.sv
module bed_checker #(
    parameter int BIN_W = 6,
    parameter int IN_W  = 8,
    parameter int PWR_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [BIN_W-1:0] in_bin,
    input logic [PWR_W-1:0] threshold,
    input logic             out_valid,
    input logic [BIN_W-1:0] out_bin,
    input logic [PWR_W-1:0] out_avg,
    input logic             out_busy,
    input logic             out_primed
);
    localparam logic [PWR_W-1:0] MAX_PWR = PWR_W'(2 * (1 << (IN_W - 1)) * (1 << (IN_W - 1)));

    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (!rst_n)          seen <= '0;
        else if (seen != 2'd3) seen <= seen + 1'b1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R6
    AST_BIN_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && out_valid) |-> (out_bin == $past(in_bin, 3))); // R6
    AST_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && out_valid) |-> (out_busy == (out_avg > $past(threshold)))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_busy); // R5
    AST_PRIMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && $past(out_primed)) |-> out_primed); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_avg <= MAX_PWR)); // R9
endmodule

bind bin_energy_detector bed_checker #(.BIN_W(BIN_W), .IN_W(IN_W), .PWR_W(PWR_W)) u_bed_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bin(in_bin),
    .threshold(threshold), .out_valid(out_valid), .out_bin(out_bin),
    .out_avg(out_avg), .out_busy(out_busy), .out_primed(out_primed)
);

// File: tb/test_bin_energy_detector.sv
module test_bin_energy_detector;
    localparam int NB = 64;
    localparam int DP = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [5:0]        in_bin = '0;
    logic signed [7:0] in_re = '0;
    logic signed [7:0] in_im = '0;
    logic [16:0]       threshold = '0;
    logic              out_valid, out_busy, out_primed;
    logic [5:0]        out_bin;
    logic [16:0]       out_avg;

    bin_energy_detector i_bin_energy_detector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_bin(in_bin), .in_re(in_re), .in_im(in_im), .threshold(threshold),
        .out_valid(out_valid), .out_bin(out_bin), .out_avg(out_avg),
        .out_busy(out_busy), .out_primed(out_primed)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    int pwr_hist [NB][DP];
    int frames = 0;

    // Expected-result pipeline, index 2 is the oldest
    bit ev [3];
    int eb [3];
    int ea [3];
    bit ep [3];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit sof, input int b, input int re, input int im);
        int p, n, s;
        @(negedge clk);
        chk("R6", "out_valid", int'(out_valid), int'(ev[2]));
        if (ev[2]) begin
            chk("R6", "out_bin", int'(out_bin), eb[2]);
            chk(cur_tag, "out_avg", int'(out_avg), ea[2]);
            chk(cur_tag, "out_primed", int'(out_primed), int'(ep[2]));
            chk("R5", "out_busy", int'(out_busy), (ea[2] > int'(threshold)) ? 1 : 0);
        end else begin
            chk("R5", "out_busy idle", int'(out_busy), 0);
        end
        for (int k = 2; k > 0; k--) begin
            ev[k] = ev[k-1]; eb[k] = eb[k-1]; ea[k] = ea[k-1]; ep[k] = ep[k-1];
        end
        ev[0] = v;
        if (v) begin
            if (sof) frames++;
            p = re * re + im * im;
            pwr_hist[b][(frames - 1) % DP] = p;
            n = (frames < DP) ? frames : DP;
            s = 0;
            for (int k = 0; k < n; k++) s += pwr_hist[b][k];
            eb[0] = b;
            ea[0] = s / DP;
            ep[0] = (frames >= DP);
        end
        in_valid = v;
        in_sof   = sof;
        in_bin   = 6'(b);
        in_re    = 8'(re);
        in_im    = 8'(im);
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, 0, 0);
    endtask

    function automatic int pat(input int b, input int f, input int seed);
        return ((b * 37 + f * 11 + seed * 5) & 255) - 128;
    endfunction

    // mode 0: pattern, 1: re=bin im=0, 2: full scale
    task automatic send_frame(input int mode, input int seed, input bit gaps);
        int re, im;
        for (int b = 0; b < NB; b++) begin
            case (mode)
                0: begin re = pat(b, frames, seed); im = pat(b + 5, frames, seed + 3); end
                1: begin re = b; im = 0; end
                default: begin re = -128; im = -128; end
            endcase
            step(1'b1, b == 0, b, re, im);
            if (gaps && (b % 5 == 2)) step(1'b0, b % 10 == 2, 0, 0, 0); // R10 stray marker
        end
    endtask

    task automatic t_reset();
        cur_tag = "R8";
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", "out_valid in reset", int'(out_valid), 0);
            chk("R8", "out_primed in reset", int'(out_primed), 0);
            chk("R8", "out_busy in reset", int'(out_busy), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "out_valid after reset", int'(out_valid), 0);
        chk("R8", "out_primed after reset", int'(out_primed), 0);
    endtask

    task automatic t_fill();
        cur_tag = "R1";
        send_frame(0, 1, 1'b0);
        cur_tag = "R3";
        for (int f = 0; f < 14; f++) send_frame(0, 1, 1'b0);
        flush();
    endtask

    task automatic t_prime();
        cur_tag = "R4";
        send_frame(0, 2, 1'b0);
        flush();
    endtask

    task automatic t_slide();
        cur_tag = "R2";
        for (int f = 0; f < 6; f++) send_frame(0, 7 + f, 1'b0);
        flush();
    endtask

    task automatic t_threshold();
        cur_tag = "R2";
        threshold = 17'd0;
        for (int f = 0; f < DP; f++) send_frame(1, 0, 1'b0);
        flush();
        cur_tag = "R5";
        threshold = 17'd100;  // bin 10 averages exactly 100
        send_frame(1, 0, 1'b0);
        flush();
        threshold = 17'd99;
        send_frame(1, 0, 1'b0);
        flush();
    endtask

    task automatic t_gaps();
        cur_tag = "R7";
        threshold = 17'd500;
        send_frame(0, 21, 1'b1);
        flush();
        cur_tag = "R10";
        for (int f = 0; f < 3; f++) send_frame(0, 30 + f, 1'b1);
        flush();
    endtask

    task automatic t_extreme();
        cur_tag = "R9";
        threshold = 17'd32767;
        for (int f = 0; f < DP; f++) send_frame(2, 0, 1'b0);
        flush();
        @(negedge clk);
        chk("R9", "full-scale held avg", int'(out_avg), 32768);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin ev[k] = 0; eb[k] = 0; ea[k] = 0; ep[k] = 0; end
        t_reset();
        t_fill();
        t_prime();
        t_slide();
        t_threshold();
        t_gaps();
        t_extreme();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule